// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a single-port synchronous static RAM of 36-bit words split into four 9-bit byte lanes (1K words by default). Address, chip selects, both address strobes, the advance input, the write controls and the write data are registered on the rising clock edge. Read data comes straight from the array at the registered address, with no output register: a read returns its word in the cycle right after the edge that took its address.

Either of two address strobes starts an access. The processor strobe has priority, but it only counts while the first chip select is low. The controller strobe has no such gate. After a strobe, a two-bit burst counter steps the low address bits when the advance input is low. It follows a linear or an interleaved order, chosen by a mode input. When the advance input is high and no strobe is active, the current address is held. An active-low output enable works without the clock and drives `dout_en`, which stands in for a tristate pin. After a deselect, `dout_en` stays low for the first cycle of the next read.

Top module: `fts_burst_sram`

## Requirements
- R1: Inputs take effect only at a rising clock edge. Changing `addr` or `din` between edges leaves `dout` unchanged.
- R2: A new address is loaded when either strobe is low. If both are low (with `sel1_n` low), only the processor strobe acts. A processor-strobe cycle is always a read and ignores the write controls in that cycle.
- R3: The processor strobe is ignored while `sel1_n` is high, so the held address stays. The controller strobe still loads with `sel1_n` high, and that access is deselected.
- R4: The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. These are sampled only in a loading cycle. A deselected access writes nothing and keeps `dout_en` low.
- R5: With `gwr_n` low, a selected non-processor cycle writes all four lanes, whatever `bwr_n` and `lane_sel_n` are.
- R6: With `gwr_n` high and `bwr_n` low, only lanes with `lane_sel_n[l]`=0 are written. Lane l is `din[9l+8:9l]`. With `gwr_n` and `bwr_n` both high, the cycle is a read.
- R7: Read data for the address registered at an edge is on `dout` in the cycle that follows that edge (flow-through).
- R8: With `burst_interleave`=0, each edge with `adv_n` low and no strobe makes the low two address bits (start + k) mod 4. The upper bits are kept.
- R9: With `burst_interleave`=1, the low two bits follow start XOR k.
- R10: An edge with `adv_n` high and no strobe keeps the address. The read repeats, or active write controls write the same address again.
- R11: `dout_en` follows `oe_n` (active low) with no clock edge.
- R12: After a deselected cycle, `dout_en` is low for the first cycle of the next read and high from its second cycle.
- R13: After reset the block is deselected and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 10 | Word address |
| sel1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| proc_strb_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | 4 | Per-lane byte select, active low |
| burst_interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | 36 | Write data |
| dout | output | 36 | Read data |
| dout_en | output | 1 | Output drive enable (replaces the tristate) |

## Verification
Every edge-driven result is due in the cycle right after the edge that takes the stimulus. This covers read data, the write that a later read shows, each burst step, and `dout_en` after a select change. So each scenario task waits for one rising edge, then 1 ns more, and samples before it changes any input. The two results that need no edge are handled differently. For the output enable, the bench toggles `oe_n` between edges and samples 1 ns later. For edge-only sampling, it changes `addr` and `din` in mid-cycle and confirms that `dout` has not moved. The masked first read after a deselect is checked over two consecutive cycles, low and then high.

// File: rtl/fts_pkg.sv
// Shared types for the flow-through burst SRAM.
// Assumes: nothing beyond IEEE 1800-2017.
package fts_pkg;

    // Which address strobe, if any, loads an address in this cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PROC = 2'd1,
        SRC_CTRL = 2'd2
    } load_src_e;

endpackage

// File: rtl/fts_strobe_ctl.sv
// Strobe arbitration, select tracking and write-lane decode.
// Picks the loading strobe (processor first, gated by sel1_n). It keeps the
// select state sampled at the last load and turns the write controls into
// per-lane enables.
// Assumes: a processor-strobe cycle is always a read.
module fts_strobe_ctl
    import fts_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proc_strb_n,
    input  logic             ctrl_strb_n,
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             sel3_n,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output load_src_e        src,
    output logic             load,
    output logic             sel_now,
    output logic             rd_now,
    output logic [LANES-1:0] we_lanes
);

    logic             sel_q;
    logic             new_sel;
    logic [LANES-1:0] lanes_req;

    // Strobe priority, select decode for this cycle.
    always_comb begin
        if (!proc_strb_n && !sel1_n) begin
            src = SRC_PROC;
        end else if (!ctrl_strb_n) begin
            src = SRC_CTRL;
        end else begin
            src = SRC_NONE;
        end
        load    = (src != SRC_NONE);
        new_sel = !sel1_n && sel2 && !sel3_n;
        sel_now = load ? new_sel : sel_q;
    end

    // Per-lane request: global write overrides byte selects.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_comb begin
                if (!gwr_n) begin
                    lanes_req[l] = 1'b1;
                end else begin
                    lanes_req[l] = !bwr_n && !lane_sel_n[l];
                end
            end
        end
    endgenerate

    // Qualify writes with select; processor-strobe cycles never write.
    always_comb begin
        we_lanes = (sel_now && (src != SRC_PROC)) ? lanes_req : '0;
        rd_now   = sel_now && (we_lanes == '0);
    end

    // Select state, sampled only on a loading edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (load) begin
            sel_q <= new_sel;
        end
    end

endmodule

// File: rtl/fts_burst_ctr.sv
// Burst address generator.
// Loads a start address on a strobe and then steps a BURST_W-bit count on
// each advance. The low bits follow a linear or an interleaved order.
// Assumes: ADDR_W > BURST_W and the order input is static during a burst.
module fts_burst_ctr #(
    parameter int ADDR_W  = 10,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    base_q;
    logic [BURST_W-1:0] start_q;
    logic [BURST_W-1:0] step_q;
    logic [BURST_W-1:0] step_nx;

    function automatic logic [BURST_W-1:0] offs(input logic [BURST_W-1:0] s,
                                                input logic [BURST_W-1:0] k,
                                                input logic il);
        return il ? (s ^ k) : BURST_W'(s + k);
    endfunction

    // Address used by this edge, and address read after the last edge.
    always_comb begin
        step_nx = advance ? BURST_W'(step_q + 1'b1) : step_q;
        wr_addr = load ? addr_in : {base_q, offs(start_q, step_nx, interleave)};
        rd_addr = {base_q, offs(start_q, step_q, interleave)};
    end

    // Burst state: reload on strobe, otherwise step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= '0;
            step_q  <= '0;
        end else if (load) begin
            base_q  <= addr_in[ADDR_W-1:BURST_W];
            start_q <= addr_in[BURST_W-1:0];
            step_q  <= '0;
        end else begin
            step_q  <= step_nx;
        end
    end

    // R10
    hold_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> ($stable(step_q) && $stable(start_q) && $stable(base_q)));

endmodule

// File: rtl/fts_array.sv
// Byte-lane storage array.
// Writes the enabled lanes at the clock edge and reads combinationally from
// the read address (flow-through).
// Assumes: storage holds no reset value.
module fts_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_lanes,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] dout
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Lane-masked write at the edge; storage is not reset.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we_lanes[l]) begin
                mem[wr_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
            end
        end
    end

    // Flow-through read path.
    always_comb begin
        dout = mem[rd_addr];
    end

endmodule

// File: rtl/fts_oe_gate.sv
// Output drive control.
// Registers whether the last edge started a read and masks the first read
// cycle after a deselect. Combines both with the asynchronous enable.
// Assumes: reset leaves the block in the deselected state.
module fts_oe_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_now,
    input  logic rd_now,
    input  logic oe_n,
    output logic dout_en
);

    logic rd_q;
    logic desel_q;
    logic mask_q;

    // Track read cycles and the deselect history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            desel_q <= 1'b1;
            mask_q  <= 1'b1;
        end else begin
            rd_q <= rd_now;
            if (!sel_now) begin
                desel_q <= 1'b1;
                mask_q  <= 1'b1;
            end else begin
                desel_q <= 1'b0;
                mask_q  <= desel_q;
            end
        end
    end

    // Drive enable: registered read, unmasked, output enable low.
    always_comb begin
        dout_en = rd_q && !mask_q && !oe_n;
    end

    // R4
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_now |=> !dout_en);

    // R12
    first_read_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && desel_q) |=> !dout_en);

endmodule

// File: rtl/fts_burst_sram.sv
// Top: flow-through synchronous burst SRAM.
// Wires strobe control, the burst counter, the lane array and the output
// gate. dout is always driven; dout_en stands in for a tristate.
// Assumes: burst_interleave is static while a burst runs.
module fts_burst_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              burst_interleave,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    load_src_e         src;
    logic              load;
    logic              sel_now;
    logic              rd_now;
    logic              advance;
    logic [LANES-1:0]  we_lanes;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    // Advance only on cycles without a strobe.
    always_comb begin
        advance = !adv_n && !load;
    end

    fts_strobe_ctl #(.LANES(LANES)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .proc_strb_n(proc_strb_n),
        .ctrl_strb_n(ctrl_strb_n),
        .sel1_n     (sel1_n),
        .sel2       (sel2),
        .sel3_n     (sel3_n),
        .gwr_n      (gwr_n),
        .bwr_n      (bwr_n),
        .lane_sel_n (lane_sel_n),
        .src        (src),
        .load       (load),
        .sel_now    (sel_now),
        .rd_now     (rd_now),
        .we_lanes   (we_lanes)
    );

    fts_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .interleave(burst_interleave),
        .addr_in   (addr),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr)
    );

    fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .we_lanes(we_lanes),
        .wr_addr (wr_addr),
        .din     (din),
        .rd_addr (rd_addr),
        .dout    (dout)
    );

    fts_oe_gate u_oe (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_now(sel_now),
        .rd_now (rd_now),
        .oe_n   (oe_n),
        .dout_en(dout_en)
    );

    // R3
    gated_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && sel1_n && ctrl_strb_n && adv_n && gwr_n && bwr_n)
        |=> $stable(dout));

    // R5
    global_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strb_n && !ctrl_strb_n && !sel1_n && sel2 && !sel3_n && !gwr_n)
        |=> (dout == $past(din)));

endmodule

// File: tb/test_fts_burst_sram.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_fts_burst_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr = '0;
    logic        sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
    logic        proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, adv_n = 1'b1;
    logic        gwr_n = 1'b1, bwr_n = 1'b1;
    logic [3:0]  lane_sel_n = 4'hF;
    logic        burst_interleave = 1'b0;
    logic        oe_n = 1'b0;
    logic [35:0] din = '0;
    logic [35:0] dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fts_burst_sram i_fts_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
        .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_sel_n(lane_sel_n),
        .burst_interleave(burst_interleave), .oe_n(oe_n), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [35:0] pat(input logic [9:0] a);
        return {a, 26'h2D1C3A5} ^ {26'h0, a};
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b1; bwr_n = 1'b1; lane_sel_n = 4'hF;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; oe_n = 1'b0;
    endtask

    task automatic write_word(input logic [9:0] a, input logic [35:0] d);
        ctrl_strb_n = 1'b0; addr = a; gwr_n = 1'b0; din = d;
        tick();
        idle();
    endtask

    task automatic read_load(input logic [9:0] a);
        ctrl_strb_n = 1'b0; addr = a;
        tick();
        idle();
    endtask

    task automatic t_reset();
        idle();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R13 dout_en after reset", {35'h0, dout_en}, 36'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_flow();
        write_word(10'h010, pat(10'h010));
        read_load(10'h010);
        chk("R7 flow-through data", dout, pat(10'h010));
        chk("R7 read enable", {35'h0, dout_en}, 36'h1);
    endtask

    task automatic t_oe_and_sample();
        oe_n = 1'b1; #1;
        chk("R11 oe_n high drops enable", {35'h0, dout_en}, 36'h0);
        oe_n = 1'b0; #1;
        chk("R11 oe_n low restores enable", {35'h0, dout_en}, 36'h1);
        addr = 10'h3FF; din = 36'hFFFFFFFFF; #2;
        chk("R1 mid-cycle inputs ignored", dout, pat(10'h010));
        tick();
        chk("R10 hold repeats read", dout, pat(10'h010));
    endtask

    task automatic t_deselect();
        ctrl_strb_n = 1'b0; sel2 = 1'b0; addr = 10'h010; gwr_n = 1'b0; din = 36'h0;
        tick();
        chk("R4 deselected enable low", {35'h0, dout_en}, 36'h0);
        idle();
        read_load(10'h010);
        chk("R4 deselected write dropped", dout, pat(10'h010));
        chk("R12 first read masked", {35'h0, dout_en}, 36'h0);
        tick();
        chk("R12 second read cycle drives", {35'h0, dout_en}, 36'h1);
        sel2 = 1'b0;
        tick();
        chk("R4 selects ignored without load", {35'h0, dout_en}, 36'h1);
        idle();
    endtask

    task automatic t_bytes();
        write_word(10'h040, 36'h0);
        ctrl_strb_n = 1'b0; addr = 10'h040; bwr_n = 1'b0; lane_sel_n = 4'b1010;
        din = 36'hFFFFFFFFF;
        tick();
        idle();
        read_load(10'h040);
        chk("R6 lanes 0 and 2 written", dout, 36'h007FC01FF);
        ctrl_strb_n = 1'b0; addr = 10'h040; gwr_n = 1'b0; bwr_n = 1'b0;
        lane_sel_n = 4'b1110; din = 36'h123456789;
        tick();
        idle();
        read_load(10'h040);
        chk("R5 global write overrides lanes", dout, 36'h123456789);
    endtask

    task automatic t_priority();
        write_word(10'h080, pat(10'h080));
        proc_strb_n = 1'b0; ctrl_strb_n = 1'b0; addr = 10'h080;
        gwr_n = 1'b0; din = 36'hABCDE0123;
        tick();
        chk("R2 processor wins, cycle is read", dout, pat(10'h080));
        chk("R2 processor read drives", {35'h0, dout_en}, 36'h1);
        proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1; gwr_n = 1'b0;
        tick();
        idle();
        tick();
        chk("R10 held address written", dout, 36'hABCDE0123);
    endtask

    task automatic t_gate();
        proc_strb_n = 1'b0; sel1_n = 1'b1; addr = 10'h010;
        tick();
        chk("R3 gated processor strobe ignored", dout, 36'hABCDE0123);
        chk("R3 access still enabled", {35'h0, dout_en}, 36'h1);
        proc_strb_n = 1'b1; ctrl_strb_n = 1'b0;
        tick();
        chk("R3 controller strobe loads deselected", {35'h0, dout_en}, 36'h0);
        idle();
        tick();
    endtask

    task automatic t_burst();
        for (int i = 0; i < 4; i++) write_word(10'h120 + 10'(i), pat(10'h120 + 10'(i)));
        burst_interleave = 1'b0;
        read_load(10'h121);
        chk("R8 linear start", dout, pat(10'h121));
        adv_n = 1'b0;
        for (int k = 1; k < 5; k++) begin
            tick();
            chk("R8 linear step", dout, pat(10'h120 + 10'((1 + k) % 4)));
        end
        adv_n = 1'b1;
        tick();
        burst_interleave = 1'b1;
        read_load(10'h121);
        chk("R9 interleaved start", dout, pat(10'h121));
        adv_n = 1'b0;
        for (int k = 1; k < 4; k++) begin
            tick();
            chk("R9 interleaved step", dout, pat(10'h120 + 10'(1 ^ k)));
        end
        adv_n = 1'b1;
        tick();
        burst_interleave = 1'b0;
    endtask

    initial begin
        t_reset();
        t_flow();
        t_oe_and_sample();
        t_deselect();
        t_bytes();
        t_priority();
        t_gate();
        t_burst();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule